// File: doc/BRIEF.md
# DDS Control-Word Load Interface

This block is the register-loading front end of a direct digital synthesizer. Over a single input stream it gathers a 40-bit word made up of a 32-bit frequency tuning word, a 5-bit phase offset and three control bits, and stages it. The word arrives either as five bytes on an 8-bit bus (parallel mode) or as forty single bits, least significant first, taken from bit 0 of the same bus (serial mode). Each accepted transfer on the stream counts as one word-clock tick. A rising edge of the update input copies the staged word into the active registers. Those registers drive the tuning word, phase offset, power-down flag and clock-multiplier enable of the synthesizer core.

The staged word uses one layout in both modes. Bits [31:0] hold the tuning word. Bit 32 holds the multiplier enable and bit 33 is reserved and must be 0. Bit 34 holds power-down and bits [39:35] hold the phase offset. In parallel mode the first byte (control byte W0) fills bits [39:32]. The four bytes after it fill the tuning word most significant byte first. A control byte whose low three bits are 011 switches the port to serial mode for good, until the next master reset.

Transfers use valid/ready. A transfer takes place in a cycle where `wr_valid` and `wr_ready` are both high. The block lowers `wr_ready` once the current word is complete: after W4 in parallel mode, or after the fortieth bit in serial mode. It also lowers `wr_ready` in the cycle where a rising edge of `upd_i` is seen. In all other cycles it accepts. A source may hold data while ready is low. Nothing is lost, but an upstream that drives `wr_valid` without waiting for ready has its surplus transfers dropped.

Top module: `dds_ctrl_load`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the tuning word, phase offset, power-down and multiplier enable read 0, the port is in parallel mode, and `wr_ready` is 1 (byte pointer back at W0).
- R2: Master reset leaves the staged 40-bit word unchanged, so an update issued after reset commits the bytes written before it.
- R3: In parallel mode the n-th accepted byte after reset or update (n = 0..4) fills staged bits [39-8n : 32-8n]; the tuning word is therefore W1..W4, most significant byte first.
- R4: `wr_ready` is 0 once all five bytes (parallel) or forty bits (serial) are staged, and in the cycle where `upd_i` rises; transfers offered while it is 0 leave the staged word unchanged.
- R5: A 0-to-1 change of `upd_i` seen at a clock edge commits the staged word; outputs change on that edge. Holding `upd_i` high commits nothing more, and the commit returns the pointer to W0 and the bit count to 0.
- R6: In parallel mode an accepted W0 whose bits [2:0] are 011 selects serial mode from the next cycle (`serial_mode_o` = 1). A byte of that value in another position does not. Only master reset returns to parallel mode.
- R7: In serial mode each accepted transfer shifts `wr_data[0]` in, with the first bit received ending up at staged bit 0 after forty transfers.
- R8: Committing a word with bit 34 = 1 and bit 33 = 0 sets `pdown_o`; committing one with bits 34 and 33 both 0 clears it.
- R9: A committed word with reserved bit 33 = 1 updates the tuning word but leaves phase offset, power-down and multiplier enable unchanged.
- R10: On a valid commit, `mult_en_o` takes bit 32 (W0 bit 0) and `phase_o` takes bits [39:35] (W0 bits [7:3]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| wr_valid | input | 1 | Word-clock transfer offered |
| wr_ready | output | 1 | Transfer can be accepted this cycle |
| wr_data | input | 8 | Byte (parallel) or bit in bit 0 (serial) |
| upd_i | input | 1 | Update strobe; its rising edge commits |
| tune_o | output | TUNE_W | Active frequency tuning word |
| phase_o | output | PHASE_W | Active phase offset |
| pdown_o | output | 1 | Active power-down flag |
| mult_en_o | output | 1 | Active reference-multiplier enable |
| serial_mode_o | output | 1 | Port is in serial mode |

## Verification
The bench builds the block with the default widths, a 32-bit tuning word and a 5-bit phase offset. This gives a 40-bit staged word that splits into exactly five bytes. With these values the bench can reach the end of the byte pointer at W4 and the fortieth serial bit, where ready must drop, with short transfer sequences. It can also check every field boundary of the control byte against a word model computed in the bench.

// File: rtl/dds_load_pkg.sv
package dds_load_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 3;            // multiplier, reserved, power-down
  localparam logic [2:0] SER_ENTRY = 3'b011;

  typedef enum logic {MODE_PAR = 1'b0, MODE_SER = 1'b1} port_mode_e;
endpackage

// File: rtl/dds_stage_port.sv
module dds_stage_port
  import dds_load_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              upd_rise,
  output logic [WORD_W-1:0] stage_o,
  output logic              serial_o
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int PTR_W  = $clog2(NBYTES + 1);
  localparam int CNT_W  = $clog2(WORD_W + 1);

  port_mode_e       mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] stage_q;
  logic             take;
  logic             room;

  assign room     = (mode_q == MODE_SER) ? (cnt_q < CNT_W'(WORD_W))
                                         : (ptr_q < PTR_W'(NBYTES));
  assign wr_ready = room && !upd_rise;
  assign take     = wr_valid && wr_ready;

  // Pointer, bit count and mode: all return to defaults on master reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PAR;
      ptr_q  <= '0;
      cnt_q  <= '0;
    end else if (upd_rise) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      if (mode_q == MODE_SER) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == '0 && wr_data[2:0] == SER_ENTRY) mode_q <= MODE_SER;
      end
    end
  end

  // Staging word: deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (take) begin
      if (mode_q == MODE_SER) begin
        stage_q <= {wr_data[0], stage_q[WORD_W-1:1]};
      end else begin
        for (int k = 0; k < NBYTES; k++) begin
          if (ptr_q == PTR_W'(k)) stage_q[WORD_W-1-BYTE_W*k -: BYTE_W] <= wr_data;
        end
      end
    end
  end

  assign stage_o  = stage_q;
  assign serial_o = (mode_q == MODE_SER);

  assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_W'(NBYTES));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W));
  assert_upd_rewind_R5: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> (ptr_q == '0 && cnt_q == '0));
  assert_serial_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SER) |=> (mode_q == MODE_SER));
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> $stable(stage_q));
endmodule

// File: rtl/dds_commit.sv
module dds_commit
  import dds_load_pkg::*;
#(
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd_rise,
  input  logic [TUNE_W+CTRL_W+PHASE_W-1:0] stage_i,
  output logic [TUNE_W-1:0]         tune_o,
  output logic [PHASE_W-1:0]        phase_o,
  output logic                      pdown_o,
  output logic                      mult_en_o
);
  localparam int WORD_W  = TUNE_W + CTRL_W + PHASE_W;
  localparam int MULT_B  = TUNE_W;
  localparam int RSV_B   = TUNE_W + 1;
  localparam int PD_B    = TUNE_W + 2;

  logic ctrl_ok;
  assign ctrl_ok = !stage_i[RSV_B];

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_o    <= '0;
      phase_o   <= '0;
      pdown_o   <= 1'b0;
      mult_en_o <= 1'b0;
    end else if (upd_rise) begin
      tune_o <= stage_i[TUNE_W-1:0];
      if (ctrl_ok) begin
        mult_en_o <= stage_i[MULT_B];
        pdown_o   <= stage_i[PD_B];
        phase_o   <= stage_i[WORD_W-1 -: PHASE_W];
      end
    end
  end

  assert_reset_defaults_R1: assert property (@(posedge clk)
    $past(rst) |-> (tune_o == '0 && phase_o == '0 && !pdown_o && !mult_en_o));
  assert_tune_commit_R5: assert property (@(posedge clk) disable iff (rst)
    upd_rise |=> tune_o == $past(stage_i[TUNE_W-1:0]));
  assert_rsv_holds_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_rise && stage_i[RSV_B]) |=> ($stable(phase_o) && $stable(pdown_o) && $stable(mult_en_o)));
  assert_pdown_enter_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_rise && !stage_i[RSV_B] && stage_i[PD_B]) |=> pdown_o);
  assert_no_commit_R5: assert property (@(posedge clk) disable iff (rst)
    !upd_rise |=> $stable(tune_o));
endmodule

// File: rtl/dds_ctrl_load.sv
module dds_ctrl_load
  import dds_load_pkg::*;
#(
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [7:0]         wr_data,
  input  logic               upd_i,
  output logic [TUNE_W-1:0]  tune_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               pdown_o,
  output logic               mult_en_o,
  output logic               serial_mode_o
);
  // The word must split into whole bytes: TUNE_W + 3 + PHASE_W divisible by 8.
  localparam int WORD_W = TUNE_W + CTRL_W + PHASE_W;

  logic              upd_q;
  logic              upd_rise;
  logic [WORD_W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) upd_q <= 1'b0;
    else     upd_q <= upd_i;
  end
  assign upd_rise = upd_i && !upd_q;

  dds_stage_port #(.WORD_W(WORD_W)) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .upd_rise (upd_rise),
    .stage_o  (stage),
    .serial_o (serial_mode_o)
  );

  dds_commit #(.TUNE_W(TUNE_W), .PHASE_W(PHASE_W)) u_commit (
    .clk       (clk),
    .rst       (rst),
    .upd_rise  (upd_rise),
    .stage_i   (stage),
    .tune_o    (tune_o),
    .phase_o   (phase_o),
    .pdown_o   (pdown_o),
    .mult_en_o (mult_en_o)
  );

  assert_ready_on_update_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !upd_q) |-> !wr_ready);
  assert_parallel_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!serial_mode_o && wr_ready == !upd_rise));
endmodule

// File: tb/dds_ctrl_load_tb.sv
module dds_ctrl_load_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        upd_i = 1'b0;
  logic [31:0] tune_o;
  logic [4:0]  phase_o;
  logic        pdown_o, mult_en_o, serial_mode_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] e_tune = '0;
  logic [4:0]  e_ph = '0;
  logic        e_pd = 1'b0, e_mult = 1'b0;

  always #10 clk = ~clk;

  dds_ctrl_load u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .upd_i(upd_i), .tune_o(tune_o), .phase_o(phase_o),
    .pdown_o(pdown_o), .mult_en_o(mult_en_o), .serial_mode_o(serial_mode_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model of a commit, from the word layout in R8..R10.
  function automatic void model_commit(input logic [39:0] w);
    e_tune = w[31:0];
    if (!w[33]) begin
      e_mult = w[32];
      e_pd   = w[34];
      e_ph   = w[39:35];
    end
  endfunction

  task automatic chk_out(input string req);
    chk({req, " tune"},  tune_o,    e_tune);
    chk({req, " phase"}, phase_o,   e_ph);
    chk({req, " pdown"}, pdown_o,   e_pd);
    chk({req, " mult"},  mult_en_o, e_mult);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic put_word(input logic [39:0] w);
    for (int k = 0; k < 5; k++) put(w[39-8*k -: 8]);
  endtask

  task automatic put_serial(input logic [39:0] w);
    for (int i = 0; i < 40; i++) put({7'b0, w[i]});
  endtask

  task automatic commit();
    @(negedge clk); upd_i = 1'b1;
    @(negedge clk); upd_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_tune = '0; e_ph = '0; e_pd = 1'b0; e_mult = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Random word with reserved bit chosen; parallel-safe W0 never has low bits 011.
  function automatic logic [39:0] rand_word(input logic rsv);
    logic [39:0] w;
    w = {$urandom, $urandom};
    w[33] = rsv;
    if (rsv) w[34] = 1'b1;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [39:0] w, w2;
    void'($urandom(32'd5150));
    do_reset();
    // R1 reset state
    chk_out("R1");
    chk("R1 serial", serial_mode_o, 1'b0);
    chk("R1 ready", wr_ready, 1'b1);

    // R3 R10 directed parallel word; W1 = 0x03 must not switch mode (R6)
    w = {8'h29, 32'h0312_5678};
    put_word(w); commit(); model_commit(w);
    chk_out("R3 R10 directed");
    chk("R10 phase", phase_o, 5'd5);
    chk("R10 mult", mult_en_o, 1'b1);
    chk("R6 non-W0 011", serial_mode_o, 1'b0);

    // R4 full after W4, extra byte ignored
    w2 = {8'h10, 32'hA5A5_0F0F};
    put_word(w2);
    @(negedge clk);
    chk("R4 ready after W4", wr_ready, 1'b0);
    put(8'hFF);
    commit(); model_commit(w2);
    chk_out("R4 extra byte ignored");

    // R4 R5 ready low on update edge; holding update high commits nothing more
    @(negedge clk); upd_i = 1'b1; wr_valid = 1'b1; wr_data = 8'h55;
    #1 chk("R4 ready on update edge", wr_ready, 1'b0);
    @(negedge clk); wr_valid = 1'b0;
    chk_out("R5 recommit same");
    w = {8'h48, 32'hDEAD_BEEF};
    put_word(w);
    chk_out("R5 held high no commit");
    @(negedge clk); upd_i = 1'b0;
    commit(); model_commit(w);
    chk_out("R5 new edge commits");

    // R8 power-down then power-up
    w = {8'b1010_0100, 32'h1111_2222};
    put_word(w); commit(); model_commit(w);
    chk("R8 enter pdown", pdown_o, 1'b1);
    w = {8'b1010_0000, 32'h3333_4444};
    put_word(w); commit(); model_commit(w);
    chk("R8 leave pdown", pdown_o, 1'b0);

    // R9 reserved set in parallel: tune only
    w = {8'b1111_0111, 32'h7777_8888};
    put_word(w); commit(); model_commit(w);
    chk_out("R9 parallel reserved");
    chk("R9 pdown kept", pdown_o, 1'b0);

    // Random parallel words
    for (int n = 0; n < 24; n++) begin
      w = rand_word(($urandom % 4) == 0);
      put_word(w); commit(); model_commit(w);
      chk_out("R3 R8 R9 R10 random parallel");
    end

    // R2 staged word survives reset
    w = rand_word(1'b0);
    put_word(w);
    do_reset();
    chk_out("R1 after reset");
    commit(); model_commit(w);
    chk_out("R2 staging kept");

    // R6 serial entry
    do_reset();
    put(8'b1100_1011);
    @(negedge clk);
    chk("R6 serial entered", serial_mode_o, 1'b1);
    commit();
    w = 40'h0;
    put_serial(w); commit(); model_commit(w);
    chk_out("R7 flush word");

    // R7 serial LSB-first, full after 40 bits
    w = {8'b0110_1101, 32'hC0DE_1234};
    put_serial(w);
    @(negedge clk);
    chk("R7 ready after 40", wr_ready, 1'b0);
    put(8'h01);
    commit(); model_commit(w);
    chk_out("R7 directed serial");
    for (int n = 0; n < 12; n++) begin
      w = rand_word(($urandom % 3) == 0);
      put_serial(w); commit(); model_commit(w);
      chk_out("R7 R8 R9 random serial");
    end
    chk("R6 serial sticky", serial_mode_o, 1'b1);
    do_reset();
    chk("R6 reset to parallel", serial_mode_o, 1'b0);

    summary();
    $finish;
  end
endmodule